// File: doc/BRIEF.md
# Programmable Output Macrocell (Registered Mode)

This block is one output cell of a simple programmable logic device, taken in the device mode where cells may hold a register. Eight product-term results come in from the AND array, each with a keep bit. Configuration bits pick how the cell behaves. In the registered configuration, the OR of all kept terms is captured by a D flip-flop on the shared clock. The pad is then enabled by the shared active-low enable pin. In the I/O configuration, the cell is purely combinatorial. Terms 1 to 7 form the sum, and term 0 acts as the cell's own output enable.

A polarity bit picks whether the pad shows the sum (active high) or its complement (active low). The cell also returns a feedback bit to the array. In the registered configuration this is the inverted register output. In the I/O configuration it is the value read back from the pad. An I/O cell whose enable term is false therefore works as a plain input. The pad is modelled as three signals: drive value, drive enable and read-back value. The flip-flop has no reset; a known sum must be clocked in before its output means anything.

Top module: `pld_out_cell`

## Requirements
- R1: The cell is active only when `syn` is 0 and `ac0` is 1. In any other setting, `pad_en` is 0 and `fb` equals `pad_in`.
- R2: With `ac1` = 0 (registered), on each rising `clk` edge the flip-flop takes the OR of all eight terms whose keep bit is 1. Between edges the pad value does not follow the terms.
- R3: Polarity bit `pol` = 1 drives the pad with the sum or register value unchanged (active high). `pol` = 0 drives its complement (active low). This holds in both configurations.
- R4: In the registered configuration, `pad_en` equals the inverse of `oe_n`: low enables the pad, high sets it to high impedance.
- R5: With `ac1` = 1 (I/O), `pad_out` is combinatorial from the OR of kept terms 1..7 and changes without a clock edge. Term 0 is not part of this sum.
- R6: In the I/O configuration, `pad_en` equals `terms[0]` AND `keep[0]`, and `oe_n` has no effect.
- R7: A term whose keep bit is 0 contributes 0 to any sum and to the I/O enable.
- R8: `fb` is the inverted flip-flop output in the registered configuration and `pad_in` in the I/O configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared register clock pin |
| oe_n | input | 1 | Shared active-low enable pin for registered cells |
| syn | input | 1 | Mode bit; 0 for registered mode |
| ac0 | input | 1 | Mode bit; 1 for registered mode |
| ac1 | input | 1 | Cell bit: 0 registered, 1 combinatorial I/O |
| pol | input | 1 | Output polarity: 1 active high, 0 active low |
| terms | input | 8 | Product-term results from the AND array; bit 0 is the I/O enable term |
| keep | input | 8 | Per-term keep bit; 0 forces the term to 0 |
| pad_in | input | 1 | Value read back from the pad |
| pad_out | output | 1 | Value driven onto the pad |
| pad_en | output | 1 | Pad driver enable; 0 is high impedance |
| fb | output | 1 | Feedback bit to the AND array |

## Verification
The bench first primes the reset-less register with a known sum. It then sweeps all four pairings of `ac1` and `pol` with pseudo-random terms, keep bits, enable and pad values, and checks every output against a behavioural model on every cycle. Some cases set term 0 high while the configuration is registered. A design that wrongly summed only seven terms would then miss a capture, and one that summed term 0 into the I/O output would show a wrong pad value. Terms are also changed mid-cycle. A registered path that leaked combinatorially, or an I/O path that waited for a clock, would show the wrong pad value before the edge. Other checks toggle `oe_n` in the I/O configuration, set masked terms high, and leave the mode bits invalid. These catch a swapped enable source, a missing disable mask, and a cell that still drives the pad when not selected.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    CELL_OFF = 2'd0,
    CELL_REG = 2'd1,
    CELL_IO  = 2'd2
  } cell_cfg_e;

  // Decode the architecture bits into the cell's role.
  function automatic cell_cfg_e decode_cfg(input logic syn_b, input logic ac0_b,
                                           input logic ac1_b);
    if (syn_b || !ac0_b) return CELL_OFF;
    return ac1_b ? CELL_IO : CELL_REG;
  endfunction

  // Polarity stage: pass when active high, invert when active low.
  function automatic logic apply_pol(input logic val, input logic act_high);
    return act_high ? val : ~val;
  endfunction

endpackage

// File: rtl/mc_term_sum.sv
module mc_term_sum #(
  parameter int N = 8
) (
  input  logic [N-1:0] terms_i,
  input  logic [N-1:0] keep_i,
  output logic         sum_o
);
  logic [N-1:0] live;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign live[g] = terms_i[g] & keep_i[g];
  end

  assign sum_o = |live;
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  // Reset-less storage element, as on the device.
  always_ff @(posedge clk) begin
    q_o <= d_i;
  end
endmodule

// File: rtl/mc_out_sel.sv
module mc_out_sel
  import mc_pkg::*;
(
  input  cell_cfg_e cfg_i,
  input  logic      pol_i,
  input  logic      q_i,
  input  logic      sum_io_i,
  input  logic      oe_term_i,
  input  logic      oe_n_i,
  input  logic      pad_in_i,
  output logic      pad_out_o,
  output logic      pad_en_o,
  output logic      fb_o
);
  always_comb begin
    pad_out_o = 1'b0;
    pad_en_o  = 1'b0;
    fb_o      = pad_in_i;
    unique case (cfg_i)
      CELL_REG: begin
        pad_out_o = apply_pol(q_i, pol_i);
        pad_en_o  = ~oe_n_i;
        fb_o      = ~q_i;
      end
      CELL_IO: begin
        pad_out_o = apply_pol(sum_io_i, pol_i);
        pad_en_o  = oe_term_i;
        fb_o      = pad_in_i;
      end
      default: begin
        pad_out_o = 1'b0;
        pad_en_o  = 1'b0;
        fb_o      = pad_in_i;
      end
    endcase
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import mc_pkg::*;
#(
  parameter int NT = 8
) (
  input  logic          clk,
  input  logic          oe_n,
  input  logic          syn,
  input  logic          ac0,
  input  logic          ac1,
  input  logic          pol,
  input  logic [NT-1:0] terms,
  input  logic [NT-1:0] keep,
  input  logic          pad_in,
  output logic          pad_out,
  output logic          pad_en,
  output logic          fb
);
  localparam int NIO = NT - 1;

  // Named internal events, visible to the checker.
  cell_cfg_e cfg;
  logic      sum_all;
  logic      sum_io;
  logic      oe_term;
  logic      ff_q;

  assign cfg     = decode_cfg(syn, ac0, ac1);
  assign oe_term = terms[0] & keep[0];

  mc_term_sum #(.N(NT)) u_sum_all (
    .terms_i (terms),
    .keep_i  (keep),
    .sum_o   (sum_all)
  );

  mc_term_sum #(.N(NIO)) u_sum_io (
    .terms_i (terms[NT-1:1]),
    .keep_i  (keep[NT-1:1]),
    .sum_o   (sum_io)
  );

  mc_store u_ff (
    .clk (clk),
    .d_i (sum_all),
    .q_o (ff_q)
  );

  mc_out_sel u_sel (
    .cfg_i     (cfg),
    .pol_i     (pol),
    .q_i       (ff_q),
    .sum_io_i  (sum_io),
    .oe_term_i (oe_term),
    .oe_n_i    (oe_n),
    .pad_in_i  (pad_in),
    .pad_out_o (pad_out),
    .pad_en_o  (pad_en),
    .fb_o      (fb)
  );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
  parameter int NT = 8
) (
  input logic          clk,
  input logic          oe_n,
  input logic          syn,
  input logic          ac0,
  input logic          ac1,
  input logic          pol,
  input logic [NT-1:0] terms,
  input logic [NT-1:0] keep,
  input logic          pad_in,
  input logic          pad_out,
  input logic          pad_en,
  input logic          fb,
  input logic          sum_all,
  input logic          ff_q
);
  // No reset on the block: count edges so checks start once the register is defined.
  logic [1:0] seen = 2'd0;
  logic       live;
  always_ff @(posedge clk) begin
    if (seen != 2'd2) seen <= seen + 2'd1;
  end
  assign live = (seen == 2'd2);

  // R2
  capture_sum_chk: assert property (@(posedge clk) disable iff (!live)
    ff_q == $past(sum_all));

  // R1
  off_no_drive_chk: assert property (@(posedge clk) disable iff (!live)
    (syn || !ac0) |-> (!pad_en && fb == pad_in));

  // R4
  reg_pin_oe_chk: assert property (@(posedge clk) disable iff (!live)
    (!syn && ac0 && !ac1) |-> (pad_en == !oe_n));

  // R6
  io_term_oe_chk: assert property (@(posedge clk) disable iff (!live)
    (!syn && ac0 && ac1) |-> (pad_en == (terms[0] && keep[0])));

  // R3
  reg_polarity_chk: assert property (@(posedge clk) disable iff (!live)
    (!syn && ac0 && !ac1) |-> (pad_out == (pol ? ff_q : !ff_q)));

  // R8
  reg_feedback_chk: assert property (@(posedge clk) disable iff (!live)
    (!syn && ac0 && !ac1) |-> (fb == !ff_q));

  // R8
  io_feedback_chk: assert property (@(posedge clk) disable iff (!live)
    (!syn && ac0 && ac1) |-> (fb == pad_in));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NT(NT)) u_chk (
  .clk     (clk),
  .oe_n    (oe_n),
  .syn     (syn),
  .ac0     (ac0),
  .ac1     (ac1),
  .pol     (pol),
  .terms   (terms),
  .keep    (keep),
  .pad_in  (pad_in),
  .pad_out (pad_out),
  .pad_en  (pad_en),
  .fb      (fb),
  .sum_all (sum_all),
  .ff_q    (ff_q)
);

// File: tb/tb_pld_out_cell.sv
module tb_pld_out_cell;
  localparam int NT = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          oe_n, syn, ac0, ac1, pol, pad_in;
  logic [NT-1:0] terms, keep;
  logic          pad_out, pad_en, fb;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  mq = 1'b0;       // model of the stored bit
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  pld_out_cell #(.NT(NT)) dut (
    .clk(clk), .oe_n(oe_n), .syn(syn), .ac0(ac0), .ac1(ac1), .pol(pol),
    .terms(terms), .keep(keep), .pad_in(pad_in),
    .pad_out(pad_out), .pad_en(pad_en), .fb(fb)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Behavioural OR over kept terms with index >= lo.
  function automatic bit ref_or(input logic [NT-1:0] t, input logic [NT-1:0] k,
                                input int lo);
    bit acc = 1'b0;
    for (int i = lo; i < NT; i++) if (t[i] === 1'b1 && k[i] === 1'b1) acc = 1'b1;
    return acc;
  endfunction

  // Model update at each rising edge.
  always @(posedge clk) mq = ref_or(terms, keep, 0);

  task automatic compare();
    bit s7;
    if (syn !== 1'b0 || ac0 !== 1'b1) begin
      check("R1 pad_en off", pad_en, 1'b0);
      check("R1 fb off", fb, pad_in);
    end else if (ac1 === 1'b0) begin
      check("R4 pad_en reg", pad_en, !oe_n);
      check("R2/R3 pad_out reg", pad_out, pol ? mq : !mq);
      check("R8 fb reg", fb, !mq);
    end else begin
      s7 = ref_or(terms, keep, 1);
      check("R6/R7 pad_en io", pad_en, terms[0] & keep[0]);
      check("R5/R3/R7 pad_out io", pad_out, pol ? s7 : !s7);
      check("R8 fb io", fb, pad_in);
    end
  endtask

  task automatic cycle(input logic s, input logic a0, input logic a1, input logic p,
                       input logic oen, input logic [NT-1:0] t, input logic [NT-1:0] k,
                       input logic pin);
    @(negedge clk);
    syn = s; ac0 = a0; ac1 = a1; pol = p; oe_n = oen; terms = t; keep = k; pad_in = pin;
    #1 compare();      // mid-cycle: combinational path live, register held
    @(posedge clk);
    #2 compare();      // just after the edge
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    syn = 0; ac0 = 1; ac1 = 0; pol = 1; oe_n = 0; terms = '0; keep = '1; pad_in = 0;
    // Prime the reset-less register with a known 0 (R2).
    cycle(0, 1, 0, 1, 0, 8'h00, 8'hff, 0);
    check("R2 primed zero", pad_out, 1'b0);
    // R2: only term 0 set still captured in registered config.
    cycle(0, 1, 0, 1, 0, 8'h01, 8'hff, 0);
    check("R2 term0 counts when registered", pad_out, 1'b1);
    // R3: active low.
    cycle(0, 1, 0, 0, 0, 8'h80, 8'hff, 1);
    check("R3 active low", pad_out, 1'b0);
    // R7: set term masked.
    cycle(0, 1, 0, 1, 0, 8'h10, 8'hef, 0);
    check("R7 masked term", pad_out, 1'b0);
    // R4: shared pin high gives high impedance.
    cycle(0, 1, 0, 1, 1, 8'h02, 8'hff, 0);
    check("R4 hi-z", pad_en, 1'b0);
    // R5: term 0 alone does not make the I/O sum.
    cycle(0, 1, 1, 1, 0, 8'h01, 8'hff, 1);
    check("R5 term0 excluded", pad_out, 1'b0);
    check("R6 term0 enables", pad_en, 1'b1);
    // R6: oe_n ignored; masked enable term makes an input.
    cycle(0, 1, 1, 1, 1, 8'h41, 8'hfe, 1);
    check("R6 oe_n ignored, enable masked", pad_en, 1'b0);
    check("R8 input feedback", fb, 1'b1);
    // R1: invalid mode bits.
    cycle(1, 1, 0, 1, 0, 8'hff, 8'hff, 1);
    check("R1 syn set", pad_en, 1'b0);
    cycle(0, 0, 1, 1, 0, 8'hff, 8'hff, 0);
    check("R1 ac0 clear", pad_en, 1'b0);
    // Random sweep across all ac1/pol pairs and occasional invalid modes.
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cycle((lfsr[20:18] == 3'b000), 1'b1, n[1], n[0], lfsr[3],
            lfsr[11:4] & lfsr[27:20], lfsr[19:12] | lfsr[31:24], lfsr[2]);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule